// File: doc/BRIEF.md
# Key-Locked DRAM Controller Register File

This block holds the 32-bit configuration space of a DRAM controller behind a word-addressed read/write bus. Writes are gated by a three-state protection lock: the lock opens only when a magic key is written to word 0, a second key freezes it until the next reset, and any other value written there closes it again. A fixed group of words (interrupt, test and software-scratch words) bypasses the lock so that they can be written at any time.

A few words alter the data written to them before it is stored. The configuration word keeps hardware-owned fields (a version number, an aperture code and the RAM-size code) no matter what software writes. The PHY status word always reads as not busy and PLL locked, and the ECC self-test control word always reads as finished and passed. The RAM size is a build parameter; only 256, 512, 1024 and 2048 MiB are legal, and any other value stops elaboration. Reads are returned one clock after the request on a registered data output.

Top module: `dram_cfg_regfile`

## Requirements
- R1: After reset every word reads zero except: word 0 (lock) reads 0x00, the configuration word at byte offset 0x04 reads 0x3000000C OR the size code, byte offset 0x400 reads 0x00000002, offsets 0x468 and 0x47C read 0x000000FF and offset 0x450 reads 0x0FFFFFFF.
- R2: When the lock is not hard-locked, a write to byte offset 0x00 stores 0x01 for data 0xFC600309, 0x10 for data 0xDEADDEAD and 0x00 for any other data; the stored code reads back at offset 0x00.
- R3: While the lock reads 0x00 (soft-locked), writes to every lock-protected word other than offset 0x00 leave it unchanged.
- R4: While the lock reads 0x10 (hard-locked), every lock-protected write, including one to offset 0x00, is discarded; only reset returns the lock to 0x00.
- R5: Byte offsets 0x50, 0x6C, 0x74, 0x78, 0x7C, 0x88, 0x8C and 0xB4 accept writes in every lock state and store the data unchanged.
- R6: A permitted write to offset 0x04 stores (data AND NOT 0xF00FC04C) OR (0x3000000C OR size code): bits 31:28 read 3, bits 3:2 read 3, bits 19:14 and bit 6 read 0, and bits 1:0 read data[1:0] OR size code.
- R7: The size code in bits 1:0 is the position of the RAM size in the list 256, 512, 1024, 2048 MiB (0 to 3); any other size is refused at elaboration.
- R8: A permitted write to offset 0x60 stores the data with bit 0 cleared and bit 4 set.
- R9: A permitted write to offset 0x70 stores the data with bit 12 set and bit 13 cleared.
- R10: Word indices at or beyond the implemented array (byte offsets 0x500 and up) read as zero and ignore writes.
- R11: A read request returns its word on rd_data at the next rising edge (the value before any write in the same cycle); without a request rd_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request for the word at addr |
| rd_en | input | 1 | Read request for the word at addr |
| addr | input | ADDR_W | Word index (byte offset divided by 4) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |

## Verification
The bench sweeps every word index of the address space in each lock state and compares every read with a reference model, so a whitelist entry off by one word, a protected word that slips through a soft or hard lock, or a lock that reopens from the hard state shows up as a single mismatching word. It writes all-ones and all-zeros to the configuration word, which exposes a wrong read-only mask or a size code taken from the wrong list position, and writes to the status and self-test words, where a missing force would leave a busy or failed bit visible. It also reads past the array, where an aliasing decoder would return a real word, and checks that the output holds between requests and that a second reset clears the hard lock.

// File: rtl/dram_cfg_pkg.sv
// Shared constants, lock encoding and per-word helper functions for the
// key-locked DRAM controller register file.
package dram_cfg_pkg;

    // Lock codes as they read back at word 0.
    typedef enum logic [7:0] {
        LK_SOFT = 8'h00,
        LK_OPEN = 8'h01,
        LK_HARD = 8'h10
    } lock_e;

    localparam logic [31:0] KEY_OPEN = 32'hFC60_0309;
    localparam logic [31:0] KEY_HARD = 32'hDEAD_DEAD;

    // Word indices whose write behaviour is special.
    localparam int W_LOCK = 0;
    localparam int W_CONF = 1;
    localparam int W_STAT = 'h60 / 4;
    localparam int W_ECC  = 'h70 / 4;

    // Configuration word: hardware-owned bits and their fixed content.
    localparam logic [31:0] CONF_RO_MASK = 32'hF00F_C04C;
    localparam logic [31:0] CONF_FIXED   = 32'h3000_000C;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_PLL_BIT  = 4;
    localparam int ECC_DONE_BIT  = 12;
    localparam int ECC_FAIL_BIT  = 13;

    // True for word indices that accept writes in every lock state.
    function automatic logic is_exempt(input int idx);
        case (idx)
            'h50/4, 'h6C/4, 'h74/4, 'h78/4,
            'h7C/4, 'h88/4, 'h8C/4, 'hB4/4: return 1'b1;
            default:                         return 1'b0;
        endcase
    endfunction

    // Size code from a RAM size in MiB; -1 when the size is not legal.
    function automatic int size_code(input int mib);
        case (mib)
            256:     return 0;
            512:     return 1;
            1024:    return 2;
            2048:    return 3;
            default: return -1;
        endcase
    endfunction

    // Value a storage word takes on reset.
    function automatic logic [31:0] reset_word(input int idx, input logic [1:0] code);
        case (idx)
            W_CONF:  return CONF_FIXED | {30'd0, code};
            'h400/4: return 32'h0000_0002;
            'h468/4: return 32'h0000_00FF;
            'h47C/4: return 32'h0000_00FF;
            'h450/4: return 32'h0FFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/dram_cfg_lock.sv
// Protection lock state machine.
// Holds the lock code shown at word 0. A write request to word 0 decodes the
// key; the hard state ignores every request until reset.
// Assumes the caller asserts key_we only for an in-range write to word 0.
module dram_cfg_lock
    import dram_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_we,
    input  logic [31:0] key_data,
    output lock_e       state
);

    lock_e next_state;

    // Key decode: next lock state for a write to word 0.
    always_comb begin
        next_state = state;
        if (key_we && state != LK_HARD) begin
            if (key_data == KEY_OPEN)      next_state = LK_OPEN;
            else if (key_data == KEY_HARD) next_state = LK_HARD;
            else                           next_state = LK_SOFT;
        end
    end

    // Lock register; reset closes the lock in the soft state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LK_SOFT;
        else        state <= next_state;
    end

endmodule

// File: rtl/dram_cfg_wfilter.sv
// Write filter.
// Decides whether a bus write may change a storage word and what data it
// stores, from the word index and the current lock state. Word 0 is routed
// to the lock machine instead of storage.
// Assumes the address is a word index; out-of-range writes produce nothing.
module dram_cfg_wfilter
    import dram_cfg_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORDS  = 320
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    input  lock_e             state,
    input  logic [1:0]        code,
    output logic              commit,
    output logic [31:0]       commit_data,
    output logic              key_we
);

    int   idx;
    logic in_range;
    logic exempt;

    // Address classification.
    always_comb begin
        idx      = int'(addr);
        in_range = idx < WORDS;
        exempt   = is_exempt(idx);
    end

    // Permission and data shaping per word.
    always_comb begin
        commit      = 1'b0;
        key_we      = 1'b0;
        commit_data = wr_data;
        if (wr_en && in_range) begin
            if (exempt) begin
                commit = 1'b1;
            end else if (state == LK_HARD) begin
                commit = 1'b0;
            end else if (idx == W_LOCK) begin
                key_we = 1'b1;
            end else if (state == LK_OPEN) begin
                commit = 1'b1;
                case (idx)
                    W_CONF: commit_data = (wr_data & ~CONF_RO_MASK) | CONF_FIXED
                                          | {30'd0, code};
                    W_STAT: begin
                        commit_data[STAT_BUSY_BIT] = 1'b0;
                        commit_data[STAT_PLL_BIT]  = 1'b1;
                    end
                    W_ECC: begin
                        commit_data[ECC_DONE_BIT] = 1'b1;
                        commit_data[ECC_FAIL_BIT] = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dram_cfg_store.sv
// Storage array and registered read port.
// One 32-bit register per word index 1..WORDS-1, each loaded with its reset
// value; word 0 shows the lock code. Reads beyond the array return zero.
// Assumes commit is only raised for in-range indices.
module dram_cfg_store
    import dram_cfg_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORDS  = 320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       commit_data,
    input  logic              rd_en,
    input  lock_e             state,
    input  logic [1:0]        code,
    output logic [31:0]       rd_data
);

    logic [WORDS-1:0][31:0] words;
    logic                   rd_in_range;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        if (i == W_LOCK) begin : g_lock
            assign words[i] = {24'd0, state};
        end else begin : g_reg
            logic [31:0] q;
            // Word register: reset value, then filtered writes.
            always_ff @(posedge clk) begin
                if (!rst_n)                                  q <= reset_word(i, code);
                else if (commit && addr == ADDR_W'(i))       q <= commit_data;
            end
            assign words[i] = q;
        end
    end

    // Range check for the read index.
    assign rd_in_range = int'(addr) < WORDS;

    // Read register: loads on request, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= 32'h0;
        else if (rd_en) rd_data <= rd_in_range ? words[addr] : 32'h0;
    end

endmodule

// File: rtl/dram_cfg_regfile.sv
// Key-locked DRAM controller register file (top).
// Word-addressed 32-bit bus; writes pass a lock filter, reads are registered.
// RAM_MIB picks the size code; only 256/512/1024/2048 are accepted.
module dram_cfg_regfile
    import dram_cfg_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int WORDS   = 320,
    parameter int RAM_MIB = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data
);

    localparam int         CODE_I    = size_code(RAM_MIB);
    localparam logic [1:0] SIZE_CODE = (CODE_I < 0) ? 2'd0 : 2'(CODE_I);

    if (CODE_I < 0) begin : g_bad_size
        $error("RAM_MIB must be 256, 512, 1024 or 2048");
    end

    lock_e       lock_state;
    logic        commit;
    logic [31:0] commit_data;
    logic        key_we;

    dram_cfg_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (key_we),
        .key_data (wr_data),
        .state    (lock_state)
    );

    dram_cfg_wfilter #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_filter (
        .wr_en       (wr_en),
        .addr        (addr),
        .wr_data     (wr_data),
        .state       (lock_state),
        .code        (SIZE_CODE),
        .commit      (commit),
        .commit_data (commit_data),
        .key_we      (key_we)
    );

    dram_cfg_store #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .addr        (addr),
        .commit_data (commit_data),
        .rd_en       (rd_en),
        .state       (lock_state),
        .code        (SIZE_CODE),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/dram_cfg_regfile_chk.sv
// Property checker for the register file, bound to every instance of the top.
module dram_cfg_regfile_chk
    import dram_cfg_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORDS  = 320
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data,
    input lock_e             lock_state,
    input logic              commit,
    input logic [31:0]       commit_data
);

    logic exempt_w;
    logic in_rng;
    assign exempt_w = is_exempt(int'(addr));
    assign in_rng   = int'(addr) < WORDS;

    AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state != LK_HARD && wr_en && in_rng && addr == '0 && wr_data == KEY_OPEN)
        |=> lock_state == LK_OPEN); // R2
    AST_SOFT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state == LK_SOFT && wr_en && addr != '0 && !exempt_w) |-> !commit); // R3
    AST_HARD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_state == LK_HARD |=> lock_state == LK_HARD); // R4
    AST_HARD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state == LK_HARD && wr_en && !exempt_w) |-> !commit); // R4
    AST_EXEMPT_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_rng && exempt_w) |-> (commit && commit_data == wr_data)); // R5
    AST_CONF_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && addr == ADDR_W'(W_CONF)) |->
        (commit_data[31:28] == 4'd3 && commit_data[3:2] == 2'd3
         && commit_data[19:14] == 6'd0 && !commit_data[6])); // R6
    AST_STAT_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && addr == ADDR_W'(W_STAT)) |->
        (!commit_data[STAT_BUSY_BIT] && commit_data[STAT_PLL_BIT])); // R8
    AST_ECC_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && addr == ADDR_W'(W_ECC)) |->
        (commit_data[ECC_DONE_BIT] && !commit_data[ECC_FAIL_BIT])); // R9
    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_rng) |=> rd_data == 32'h0); // R10
    AST_OOR_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_rng |-> !commit); // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R11

endmodule

bind dram_cfg_regfile dram_cfg_regfile_chk #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .lock_state  (lock_state),
    .commit      (commit),
    .commit_data (commit_data)
);

// File: tb/dram_cfg_regfile_test.sv
`timescale 1ns/1ps
module dram_cfg_regfile_test;

    localparam int ADDR_W  = 10;
    localparam int WORDS   = 320;
    localparam int SPAN    = 1 << ADDR_W;
    localparam int RAM_MIB = 512;
    localparam logic [31:0] CODE = 32'd1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wr_data = '0;
    logic [31:0]       rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] model [WORDS];
    logic [7:0]  lk;

    always #2 clk = ~clk;

    dram_cfg_regfile #(.ADDR_W(ADDR_W), .WORDS(WORDS), .RAM_MIB(RAM_MIB)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic bit exempt(input int a);
        return a == 'h14 || a == 'h1B || a == 'h1D || a == 'h1E ||
               a == 'h1F || a == 'h22 || a == 'h23 || a == 'h2D;
    endfunction

    // Requirement tag for a word, given the default for plain words.
    function automatic string tag(input int a, input string dflt);
        if (a >= WORDS) return "R10";
        if (a == 0)     return "R2";
        if (exempt(a))  return "R5";
        if (a == 1)     return "R6";
        if (a == 'h18)  return "R8";
        if (a == 'h1C)  return "R9";
        return dflt;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < WORDS; i++) model[i] = 32'h0;
        model[1]         = 32'h3000_000C | CODE;
        model['h400 / 4] = 32'h2;
        model['h468 / 4] = 32'hFF;
        model['h47C / 4] = 32'hFF;
        model['h450 / 4] = 32'h0FFF_FFFF;
        lk = 8'h00;
    endtask

    task automatic model_write(input int a, input logic [31:0] d);
        if (a >= WORDS) return;
        if (exempt(a)) begin model[a] = d; return; end
        if (lk == 8'h10) return;
        if (a == 0) begin
            lk = (d == 32'hFC60_0309) ? 8'h01 : (d == 32'hDEAD_DEAD) ? 8'h10 : 8'h00;
            return;
        end
        if (lk != 8'h01) return;
        case (a)
            1:     model[a] = (d & ~32'hF00F_C04C) | 32'h3000_000C | CODE;
            'h18:  model[a] = (d & ~32'h1) | 32'h10;
            'h1C:  model[a] = (d & ~32'h2000) | 32'h1000;
            default: model[a] = d;
        endcase
    endtask

    function automatic logic [31:0] expect_word(input int a);
        if (a >= WORDS) return 32'h0;
        if (a == 0)     return {24'd0, lk};
        return model[a];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        addr = ADDR_W'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic check(input logic [31:0] exp, input string req, input int a);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s word 0x%0h: got 0x%08h expected 0x%08h", req, a, rd_data, exp);
        end
    endtask

    task automatic read_check(input int a, input string req);
        addr = ADDR_W'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(expect_word(a), req, a);
    endtask

    task automatic sweep_write(input logic [31:0] seed);
        for (int a = 1; a < SPAN; a++) bus_write(a, (32'(a) * 32'h9E37_79B1) ^ seed);
    endtask

    task automatic sweep_read(input string dflt);
        for (int a = 0; a < SPAN; a++) read_check(a, tag(a, dflt));
    endtask

    initial begin
        do_reset();
        // R1: reset image over the whole address space; R10 beyond the array
        sweep_read("R1");
        read_check(1, "R7");

        // R3: soft-locked sweep, only exempt words (R5) change
        sweep_write(32'hA5A5_0000);
        sweep_read("R3");

        // R2: key decode
        bus_write(0, 32'h1234_5678); read_check(0, "R2");
        bus_write(0, 32'hFC60_0309); read_check(0, "R2");
        bus_write(0, 32'hFC60_0308); read_check(0, "R2");
        bus_write(0, 32'hFC60_0309); read_check(0, "R2");

        // Unlocked sweep: plain words, conf (R6), status (R8), ECC (R9)
        sweep_write(32'h0F0F_5A5A);
        sweep_read("R2");

        // R6 and R7: configuration with all-ones and all-zeros
        bus_write(1, 32'hFFFF_FFFF); read_check(1, "R6");
        bus_write(1, 32'h0000_0000); read_check(1, "R7");
        bus_write('h18, 32'h0000_0001); read_check('h18, "R8");
        bus_write('h1C, 32'h0000_2000); read_check('h1C, "R9");

        // R11: output holds without a request
        read_check(5, "R11");
        bus_write(5, 32'hCAFE_F00D);
        bus_write('h14, 32'h7777_7777);
        @(negedge clk);
        check(model[5] == 32'hCAFE_F00D ? 32'h0F0F_5A5A ^ (32'd5 * 32'h9E37_79B1) : 32'hX,
              "R11", 5);
        // R11: same-cycle read and write returns the old value
        addr = ADDR_W'(6); wr_data = 32'h1111_2222; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(model[6], "R11", 6);
        model_write(6, 32'h1111_2222);
        read_check(6, "R11");

        // R4: hard lock, key writes ignored, only exempt words change
        bus_write(0, 32'hDEAD_DEAD); read_check(0, "R4");
        bus_write(0, 32'hFC60_0309); read_check(0, "R4");
        bus_write(0, 32'h0000_0000); read_check(0, "R4");
        sweep_write(32'h3C3C_C3C3);
        sweep_read("R4");
        bus_write(1, 32'h0); read_check(1, "R4");

        // R4: reset leaves hard lock
        do_reset();
        sweep_read("R1");
        bus_write(0, 32'hFC60_0309); read_check(0, "R4");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule